// File: doc/BRIEF.md
# Register Busy-Bit Issue Gate

This block sits between instruction decode and the execution units of an in-order, single-issue pipeline. Each cycle it is offered at most one decoded operation. The operation carries two source register indices, a destination index, an operation class and a store flag. The block keeps one busy bit per architectural register. It holds the operation back while any register the operation names is busy. Because the check is done in hardware, correct ordering never depends on software knowing how long an operation takes.

When a load, multiply, divide or floating-point operation dispatches, the block marks its destination register busy. A store instead marks the register that supplies its store data. Short operations such as add and logic dispatch without setting anything. Two completion ports, one per long-latency return path, clear busy bits. A completion is seen by the hazard check in the cycle it is reported, so a waiting operation can leave in that same cycle.

Top module: `sb_issue_gate`

## Requirements
- R1: While reset is asserted, and until the block leaves reset, `busy_vec` reads all zeros and `op_ready` is low. Reset is asserted asynchronously and released in step with the clock.
- R2: Dispatching an operation whose `op_class` is 2 (load), 3 (multiply), 4 (divide) or 5 (floating point), with `op_store` low, sets bit `op_dst` of `busy_vec` on the following cycle.
- R3: Dispatching with `op_store` high, whatever the class, sets bit `op_src1` (the store-data register) on the next cycle and leaves bit `op_dst` alone. A store does not check `op_dst` for hazards.
- R4: Dispatching with `op_class` 0 (add), 1 (logic), 6 or 7 and `op_store` low sets no busy bit.
- R5: An operation whose `op_src0` or `op_src1` is busy, or whose `op_dst` is busy when it is not a store, sees `op_ready` low. While it waits, no busy bit goes from clear to set.
- R6: Register 0 is never busy, and it never causes a stall.
- R7: A completion (`cmpl_valid[k]` high, with index `cmpl_idx[k*5 +: 5]`) clears that register's bit on the next cycle. In the same cycle it also stops that register from blocking the offered operation.
- R8: When a dispatch sets a register that a completion clears in the same cycle, the bit ends up busy.
- R9: `op_ready` is combinational. An operation dispatches exactly when `op_valid` and `op_ready` are both high, and `stall` equals `op_valid` and not `op_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A decoded operation is offered |
| op_ready | output | 1 | The offered operation can dispatch this cycle |
| stall | output | 1 | The offered operation is held back |
| op_src0 | input | 5 | First source register index |
| op_src1 | input | 5 | Second source register index (store data for stores) |
| op_dst | input | 5 | Destination register index |
| op_class | input | 3 | Operation class code |
| op_store | input | 1 | Operation is a store |
| cmpl_valid | input | 2 | Per completion port: a result returns |
| cmpl_idx | input | 10 | Per completion port: 5-bit register index, port k at bits k*5 +: 5 |
| busy_vec | output | 32 | Current busy bit of every register |

## Verification
The bench builds the block with its default configuration of 32 registers and two completion ports. This is small enough to sweep every register index against every class code. It also places every register in each of the three hazard positions and on both completion ports. The sweeps reach the set-over-clear collision, the same-cycle release of a waiting operation, simultaneous completions and every use of register 0. Expected ready and busy values come from a bit-vector model written straight from the requirements.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [2:0] {
    CLS_ADD   = 3'd0,
    CLS_LOGIC = 3'd1,
    CLS_LOAD  = 3'd2,
    CLS_MUL   = 3'd3,
    CLS_DIV   = 3'd4,
    CLS_FPU   = 3'd5,
    CLS_RSV6  = 3'd6,
    CLS_RSV7  = 3'd7
  } op_class_e;

  // Classes whose result returns through a completion port
  function automatic logic is_long_class(input op_class_e cls);
    return (cls == CLS_LOAD) || (cls == CLS_MUL) ||
           (cls == CLS_DIV)  || (cls == CLS_FPU);
  endfunction

endpackage

// File: rtl/sb_rst_sync.sv
module sb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/sb_decode.sv
module sb_decode
  import sb_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [IW-1:0]   src0,
  input  logic [IW-1:0]   src1,
  input  logic [IW-1:0]   dst,
  input  op_class_e       cls,
  input  logic            store,
  output logic [NREG-1:0] ref_mask,
  output logic [NREG-1:0] set_mask
);

  logic [NREG-1:0] src0_oh, src1_oh, dst_oh;

  always_comb begin
    src0_oh = '0;
    src1_oh = '0;
    dst_oh  = '0;
    src0_oh[src0] = 1'b1;
    src1_oh[src1] = 1'b1;
    dst_oh[dst]   = 1'b1;
  end

  always_comb begin
    // A store has no target; its data register is read, not written
    ref_mask = src0_oh | src1_oh | (store ? '0 : dst_oh);
    if (store)                   set_mask = src1_oh;
    else if (is_long_class(cls)) set_mask = dst_oh;
    else                         set_mask = '0;
    // Register zero never holds a pending result
    ref_mask[0] = 1'b0;
    set_mask[0] = 1'b0;
  end

endmodule

// File: rtl/sb_cmpl_clear.sv
module sb_cmpl_clear #(
  parameter int NREG  = 32,
  parameter int NCMPL = 2,
  localparam int IW   = $clog2(NREG)
) (
  input  logic [NCMPL-1:0]    cmpl_valid,
  input  logic [NCMPL*IW-1:0] cmpl_idx,
  output logic [NREG-1:0]     clr_mask
);

  logic [NCMPL-1:0][NREG-1:0] port_mask;

  for (genvar k = 0; k < NCMPL; k++) begin : g_port
    always_comb begin
      port_mask[k] = '0;
      if (cmpl_valid[k]) port_mask[k][cmpl_idx[k*IW +: IW]] = 1'b1;
    end
  end

  always_comb begin
    clr_mask = '0;
    for (int k = 0; k < NCMPL; k++) clr_mask = clr_mask | port_mask[k];
  end

endmodule

// File: rtl/sb_busy_file.sv
module sb_busy_file #(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [NREG-1:0] set_mask,
  input  logic [NREG-1:0] clr_mask,
  output logic [NREG-1:0] busy_q
);

  logic [NREG-1:0] busy_d;
  logic            upd_en;

  always_comb begin
    upd_en = set_en || (|clr_mask);
    // Set is applied after clear, so a colliding set wins
    busy_d = (busy_q & ~clr_mask) | (set_en ? set_mask : '0);
    busy_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_q <= '0;
    else if (upd_en) busy_q <= busy_d;
  end

endmodule

// File: rtl/sb_issue_gate.sv
module sb_issue_gate
  import sb_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int NCMPL = 2,
  localparam int IW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  output logic              stall,
  input  logic [IW-1:0]     op_src0,
  input  logic [IW-1:0]     op_src1,
  input  logic [IW-1:0]     op_dst,
  input  logic [2:0]        op_class,
  input  logic              op_store,
  input  logic [NCMPL-1:0]  cmpl_valid,
  input  logic [NCMPL*IW-1:0] cmpl_idx,
  output logic [NREG-1:0]   busy_vec
);

  logic            rst_q_n;
  logic [NREG-1:0] ref_mask, set_mask, clr_mask, busy_q, busy_eff;
  logic            hazard, dispatch;

  sb_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  sb_decode #(.NREG(NREG)) u_dec (
    .src0     (op_src0),
    .src1     (op_src1),
    .dst      (op_dst),
    .cls      (op_class_e'(op_class)),
    .store    (op_store),
    .ref_mask (ref_mask),
    .set_mask (set_mask)
  );

  sb_cmpl_clear #(.NREG(NREG), .NCMPL(NCMPL)) u_clr (
    .cmpl_valid (cmpl_valid),
    .cmpl_idx   (cmpl_idx),
    .clr_mask   (clr_mask)
  );

  always_comb begin
    // Completions reported now already release their registers
    busy_eff = busy_q & ~clr_mask;
    hazard   = |(ref_mask & busy_eff);
    op_ready = rst_q_n && !hazard;
    dispatch = op_valid && op_ready;
    stall    = op_valid && !op_ready;
  end

  sb_busy_file #(.NREG(NREG)) u_busy (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .set_en   (dispatch),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .busy_q   (busy_q)
  );

  assign busy_vec = busy_q;

endmodule

// File: rtl/sb_issue_gate_chk.sv
module sb_issue_gate_chk #(
  parameter int NREG = 32,
  parameter int IW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_q_n,
  input logic            op_valid,
  input logic            op_ready,
  input logic            stall,
  input logic [IW-1:0]   op_src1,
  input logic [IW-1:0]   op_dst,
  input logic [2:0]      op_class,
  input logic            op_store,
  input logic [NREG-1:0] busy_vec
);

  logic go, long_op;
  assign go      = op_valid && op_ready;
  assign long_op = (op_class >= 3'd2) && (op_class <= 3'd5) && !op_store;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (busy_vec == '0));

  // R1
  reset_ready_chk: assert property (@(posedge clk)
    !rst_q_n |-> !op_ready);

  // R2
  long_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (go && long_op && op_dst != '0) |=> busy_vec[$past(op_dst)]);

  // R3
  store_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (go && op_store && op_src1 != '0) |=> busy_vec[$past(op_src1)]);

  // R4
  short_noset_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (go && !op_store && !long_op) |=> ((busy_vec & ~$past(busy_vec)) == '0));

  // R5
  stall_noset_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    stall |=> ((busy_vec & ~$past(busy_vec)) == '0));

  // R6
  reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy_vec[0]);

  // R9
  handshake_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    stall == (op_valid && !op_ready));

endmodule

bind sb_issue_gate sb_issue_gate_chk #(.NREG(NREG), .IW(IW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_q_n  (rst_q_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .stall    (stall),
  .op_src1  (op_src1),
  .op_dst   (op_dst),
  .op_class (op_class),
  .op_store (op_store),
  .busy_vec (busy_vec)
);

// File: tb/sb_issue_gate_test.sv
`timescale 1ns/1ps
module sb_issue_gate_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        op_ready, stall;
  logic [4:0]  op_src0, op_src1, op_dst;
  logic [2:0]  op_class;
  logic        op_store;
  logic [1:0]  cmpl_valid;
  logic [9:0]  cmpl_idx;
  logic [31:0] busy_vec;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model = '0;

  always #2 clk = ~clk;

  sb_issue_gate uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .stall(stall), .op_src0(op_src0), .op_src1(op_src1), .op_dst(op_dst),
    .op_class(op_class), .op_store(op_store), .cmpl_valid(cmpl_valid),
    .cmpl_idx(cmpl_idx), .busy_vec(busy_vec)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] oh(logic [4:0] r);
    logic [31:0] m = '0;
    m[r] = 1'b1;
    m[0] = 1'b0;
    return m;
  endfunction

  // One cycle: drive, check handshake mid-cycle, update model, check state
  task automatic step(string tag, logic v, logic [4:0] s0, logic [4:0] s1,
                      logic [4:0] d, logic [2:0] cls, logic st,
                      logic cv0, logic [4:0] ci0, logic cv1, logic [4:0] ci1);
    logic [31:0] clr, refs, setm, eff;
    logic        rdy;
    @(negedge clk);
    op_valid = v; op_src0 = s0; op_src1 = s1; op_dst = d;
    op_class = cls; op_store = st;
    cmpl_valid = {cv1, cv0}; cmpl_idx = {ci1, ci0};
    clr  = (cv0 ? oh(ci0) : '0) | (cv1 ? oh(ci1) : '0);
    refs = oh(s0) | oh(s1) | (st ? '0 : oh(d));
    setm = st ? oh(s1) : ((cls >= 3'd2 && cls <= 3'd5) ? oh(d) : '0);
    eff  = model & ~clr;
    rdy  = ((refs & eff) == '0);
    #1;
    check({tag, " R9 ready"}, {31'd0, op_ready}, {31'd0, rdy});
    check({tag, " R9 stall"}, {31'd0, stall}, {31'd0, v && !rdy});
    @(posedge clk);
    model = eff | ((v && rdy) ? setm : '0);
    #1;
    check({tag, " busy"}, busy_vec, model);
  endtask

  task automatic idle();
    step("idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op_valid = 0; op_src0 = 0; op_src1 = 0; op_dst = 0; op_class = 0;
    op_store = 0; cmpl_valid = 0; cmpl_idx = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset busy", busy_vec, '0);
    op_valid = 1;
    #0.5;
    check("R1 reset ready", {31'd0, op_ready}, 32'd0);
    op_valid = 0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 after release", busy_vec, '0);

    // R2 / R4: every class against every destination, then clear
    for (int c = 0; c < 8; c++) begin
      for (int r = 1; r < 32; r++) begin
        step((c >= 2 && c <= 5) ? "R2 long set" : "R4 short noset",
             1, 0, 0, 5'(r), 3'(c), 0, 0, 0, 0, 0);
        step("R7 clear", 0, 0, 0, 0, 0, 0, (r % 2) == 0, 5'(r), (r % 2) == 1, 5'(r));
      end
    end

    // R3: store marks data register, not destination
    for (int r = 1; r < 32; r++) begin
      step("R3 store", 1, 0, 5'(r), 5'(32 - r), 3'(r % 8), 1, 0, 0, 0, 0);
      step("R3 dst free", 1, 0, 0, 5'(32 - r), 0, 0, 0, 0, 0, 0);
      step("R3 store dst unchecked", 1, 0, 0, 5'(r), 0, 1, 0, 0, 0, 0);
      step("R7 clear", 0, 0, 0, 0, 0, 0, 1, 5'(r), 0, 0);
    end

    // R5 / R7: each hazard position, then same-cycle release
    for (int r = 1; r < 32; r++) begin
      step("R2 set", 1, 0, 0, 5'(r), 3'd2, 0, 0, 0, 0, 0);
      step("R5 src0 stall", 1, 5'(r), 0, 0, 3'd3, 0, 0, 0, 0, 0);
      step("R5 src1 stall", 1, 0, 5'(r), 5'(r ^ 1), 3'd4, 0, 0, 0, 0, 0);
      step("R5 dst stall", 1, 0, 0, 5'(r), 3'd0, 0, 0, 0, 0, 0);
      step("R5 store src1 stall", 1, 0, 5'(r), 0, 0, 1, 0, 0, 0, 0);
      step("R7 same-cycle release", 1, 5'(r), 0, 0, 0, 0,
           (r % 2) == 1, 5'(r), (r % 2) == 0, 5'(r));
    end

    // R6: register zero in every role
    step("R6 long dst0", 1, 0, 0, 0, 3'd2, 0, 0, 0, 0, 0);
    step("R6 store src1 0", 1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R6 all zero refs", 1, 0, 0, 0, 3'd5, 0, 1, 0, 1, 0);

    // R8: set and clear collide on the same register
    for (int r = 1; r < 32; r++) begin
      step("R2 set", 1, 0, 0, 5'(r), 3'd5, 0, 0, 0, 0, 0);
      step("R8 set wins", 1, 0, 0, 5'(r), 3'd3, 0, 1, 5'(r), 0, 0);
      step("R7 clear", 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'(r));
    end

    // R7: both ports clearing different registers at once
    for (int r = 1; r < 31; r++) begin
      step("R2 set a", 1, 0, 0, 5'(r), 3'd2, 0, 0, 0, 0, 0);
      step("R2 set b", 1, 0, 0, 5'(r + 1), 3'd4, 0, 0, 0, 0, 0);
      step("R5 both busy", 1, 5'(r), 5'(r + 1), 0, 0, 0, 0, 0, 0, 0);
      step("R7 dual release", 1, 5'(r), 5'(r + 1), 0, 0, 0, 1, 5'(r), 1, 5'(r + 1));
    end
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule